// File: doc/BRIEF.md
# Cascaded Level-Interrupt Aggregator

This block collects a set of peripheral interrupt request lines and presents them to a parent interrupt controller as one level-high request. Each line passes through a two-stage synchronizer, is adjusted by a per-line polarity bit, and then feeds a per-line status bit. In level mode a status bit follows the adjusted line. In edge mode a status bit latches on an inactive-to-active transition and holds until software clears it.

Software reaches five 32-bit registers over a simple synchronous bus: address, write enable, write data, and a registered read data port with one cycle of latency. The registers are control (global enable and capture mode), line enable, status, write-one-to-clear, and polarity. The output to the parent is high while the global enable is set and at least one status bit has its enable bit set.

Top module: `irq_gather_top`

## Requirements
- R1: After reset, control, enable, polarity and clear read zero and the cascade output is low. Once every input has sat at its inactive level (high, under the reset polarity) for three cycles, status reads zero.
- R2: Enable (byte offset 0x04) and polarity (0x10) hold bits 17:0 exactly as written. Bits 31:18 of enable, status (0x08) and polarity always read zero.
- R3: Control (0x00) keeps bit 31 (global enable) and bit 30 (1 = edge capture, 0 = level). All its other bits read zero.
- R4: In level mode, each status bit equals the adjusted input. Polarity bit 1 means active-high and 0 means active-low. A change on an input pin reaches status, and so the cascade output, on the third rising clock edge.
- R5: In edge mode, an inactive-to-active transition of the adjusted input sets its status bit. The bit stays set after the input goes inactive again.
- R6: In edge mode, writing a 1 to a bit of clear (0x0C) clears that status bit, and writing 0 has no effect. A cleared bit stays clear while the input stays active with no new transition. Clear always reads zero.
- R7: If an edge and a clear of the same bit land on the same clock edge, the status bit ends up set.
- R8: In level mode, a clear write has no lasting effect on a status bit whose input stays active.
- R9: The cascade output is high exactly when control bit 31 is set and (status AND enable) is nonzero.
- R10: Reads of any other address return zero, and writes to them change no register.
- R11: A read returns the register contents from the clock edge that captured the address. A write made on that same edge shows on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 18 | Raw peripheral request lines |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cascade_irq | output | 1 | Level-high request to the parent controller |

## Verification
The bench pins down the synchronizer latency by watching the cascade output on each of the three edges after an input change. A design with a missing or an extra stage shows the request one cycle early or one cycle late. It lines up a new edge and a clear of the same bit on one clock edge; a design that gives the clear priority loses that interrupt. It checks that a clear in level mode is overridden while the input is active, and that a clear in edge mode sticks while the input stays active without a new transition. Aliased and unmapped addresses are written with all ones to catch partial address decoding.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_ENA  = 8'h04;
  localparam logic [7:0] OFF_STS  = 8'h08;
  localparam logic [7:0] OFF_CLR  = 8'h0C;
  localparam logic [7:0] OFF_POL  = 8'h10;

  localparam int CTRL_GEN_BIT  = 31;
  localparam int CTRL_EDGE_BIT = 30;

  // Polarity 1: active-high; polarity 0: active-low.
  function automatic logic line_active(input logic raw, input logic pol);
    return pol ? raw : ~raw;
  endfunction

  function automatic logic line_rise(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Next status: level mode tracks, edge mode latches with edge over clear.
  function automatic logic line_next(input logic edge_mode, input logic cur_st,
                                     input logic act, input logic rise,
                                     input logic clr);
    logic nxt;
    if (!edge_mode) nxt = act;
    else            nxt = (cur_st & ~clr) | rise;
    return nxt;
  endfunction

  function automatic logic addr_mapped(input logic [7:0] a);
    return (a == OFF_CTRL) || (a == OFF_ENA) || (a == OFF_STS) ||
           (a == OFF_CLR)  || (a == OFF_POL);
  endfunction
endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
  parameter int WIDTH  = 18,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/irqg_line_bank.sv
module irqg_line_bank
  import irqg_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] pol_mask,
  input  logic             edge_mode,
  input  logic [WIDTH-1:0] clr_pulse,
  output logic [WIDTH-1:0] status,
  output logic [WIDTH-1:0] active,
  output logic [WIDTH-1:0] rise
);
  logic [WIDTH-1:0] prev_act;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
      assign active[i] = line_active(sync_in[i], pol_mask[i]);
      assign rise[i]   = line_rise(active[i], prev_act[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_act[i] <= 1'b0;
          status[i]   <= 1'b0;
        end else begin
          prev_act[i] <= active[i];
          status[i]   <= line_next(edge_mode, status[i], active[i], rise[i], clr_pulse[i]);
        end
      end

      AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && rise[i]) |=> status[i]); // R7
      AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && status[i] && !clr_pulse[i]) |=> status[i]); // R5
      AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && clr_pulse[i] && !rise[i]) |=> !status[i]); // R6
      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode) |=> (status[i] == $past(active[i]))); // R4
    end
  endgenerate
endmodule

// File: rtl/irqg_regfile.sv
module irqg_regfile
  import irqg_pkg::*;
#(
  parameter int WIDTH  = 18,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [WIDTH-1:0]  status,
  output logic [WIDTH-1:0]  en_mask,
  output logic [WIDTH-1:0]  pol_mask,
  output logic              gen_en,
  output logic              edge_mode,
  output logic [WIDTH-1:0]  clr_pulse
);
  localparam int PAD = DATA_W - WIDTH;

  logic [7:0]        a8;
  logic              hit_ctrl, hit_ena, hit_sts, hit_clr, hit_pol, mapped;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  assign a8       = 8'(bus_addr);
  assign hit_ctrl = (a8 == OFF_CTRL);
  assign hit_ena  = (a8 == OFF_ENA);
  assign hit_sts  = (a8 == OFF_STS);
  assign hit_clr  = (a8 == OFF_CLR);
  assign hit_pol  = (a8 == OFF_POL);
  assign mapped   = addr_mapped(a8);
  assign unused_wbits = ^bus_wdata[CTRL_EDGE_BIT-1:WIDTH];

  assign clr_pulse = (bus_we && hit_clr) ? bus_wdata[WIDTH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask   <= '0;
      pol_mask  <= '0;
      gen_en    <= 1'b0;
      edge_mode <= 1'b0;
    end else if (bus_we) begin
      if (hit_ena) en_mask  <= bus_wdata[WIDTH-1:0];
      if (hit_pol) pol_mask <= bus_wdata[WIDTH-1:0];
      if (hit_ctrl) begin
        gen_en    <= bus_wdata[CTRL_GEN_BIT];
        edge_mode <= bus_wdata[CTRL_EDGE_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[CTRL_GEN_BIT]  = gen_en;
      rd_mux[CTRL_EDGE_BIT] = edge_mode;
    end
    if (hit_ena) rd_mux = {{PAD{1'b0}}, en_mask};
    if (hit_sts) rd_mux = {{PAD{1'b0}}, status};
    if (hit_pol) rd_mux = {{PAD{1'b0}}, pol_mask};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |=> (bus_rdata == '0)); // R10
  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !mapped) |=> ($stable(en_mask) && $stable(pol_mask) &&
                             $stable(gen_en) && $stable(edge_mode))); // R10
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_clr |=> (bus_rdata == '0)); // R6
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_ctrl) |=> (bus_rdata[DATA_W-1:WIDTH] == '0)); // R2
  AST_ENA_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_ena) |=> (en_mask == $past(bus_wdata[WIDTH-1:0]))); // R2
  AST_POL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_pol) |=> (pol_mask == $past(bus_wdata[WIDTH-1:0]))); // R2
endmodule

// File: rtl/irq_gather_top.sv
module irq_gather_top #(
  parameter int NUM_LINES   = 18,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 cascade_irq
);
  logic [NUM_LINES-1:0] sync_q, status, active, rise;
  logic [NUM_LINES-1:0] en_mask, pol_mask, clr_pulse, pending;
  logic                 gen_en, edge_mode;

  irqg_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(sync_q));

  irqg_line_bank #(.WIDTH(NUM_LINES)) u_lines (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_q), .pol_mask(pol_mask),
    .edge_mode(edge_mode), .clr_pulse(clr_pulse), .status(status),
    .active(active), .rise(rise));

  irqg_regfile #(.WIDTH(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status(status),
    .en_mask(en_mask), .pol_mask(pol_mask), .gen_en(gen_en),
    .edge_mode(edge_mode), .clr_pulse(clr_pulse));

  assign pending     = status & en_mask;
  assign cascade_irq = gen_en & (|pending);

  AST_CASCADE_NEEDS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_irq |-> gen_en); // R9
  AST_CASCADE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_irq |-> ((status & en_mask) != '0)); // R9
  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0)); // R5
endmodule

// File: tb/sim_irq_gather_top.sv
`timescale 1ns/1ps
module sim_irq_gather_top;
  localparam int N = 18;
  localparam logic [31:0] MASK = 32'h0003_FFFF;
  localparam logic [7:0] A_CTRL = 8'h00, A_ENA = 8'h04, A_STS = 8'h08,
                         A_CLR = 8'h0C, A_POL = 8'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '1;
  logic [7:0]  bus_addr = 8'h40;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cascade_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_gather_top u0 (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cascade_irq(cascade_irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h40;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b0;
    @(negedge clk); d = bus_rdata; bus_addr = 8'h40;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_ENA, v);  chk("R1 enable", v, 0);
    rd(A_POL, v);  chk("R1 polarity", v, 0);
    rd(A_CLR, v);  chk("R1 clear", v, 0);
    idle(4);
    rd(A_STS, v);  chk("R1 status", v, 0);
    chk("R1 cascade", {31'b0, cascade_irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_ENA, 32'hFFFF_FFFF); rd(A_ENA, v); chk("R2 enable all", v, MASK);
    wr(A_ENA, 32'h1234_5678); rd(A_ENA, v); chk("R2 enable pattern", v, 32'h1234_5678 & MASK);
    wr(A_POL, 32'hFFF2_A5A5); rd(A_POL, v); chk("R2 polarity pattern", v, 32'hFFF2_A5A5 & MASK);
    rd(A_STS, v); chk("R2 status upper zero", v & ~MASK, 0);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R3 ctrl all", v, 32'hC000_0000);
    wr(A_CTRL, 32'h4000_0001); rd(A_CTRL, v); chk("R3 ctrl edge only", v, 32'h4000_0000);
    wr(A_CTRL, 0); wr(A_ENA, 0); wr(A_POL, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(A_ENA, 32'h20); wr(A_CTRL, 32'h8000_0000);
    chk("R9 cascade idle", {31'b0, cascade_irq}, 0);
    @(negedge clk); irq_in[5] = 1'b0;
    @(negedge clk); chk("R4 latency edge1", {31'b0, cascade_irq}, 0);
    @(negedge clk); chk("R4 latency edge2", {31'b0, cascade_irq}, 0);
    @(negedge clk); chk("R4 latency edge3", {31'b0, cascade_irq}, 1);
    rd(A_STS, v); chk("R4 active-low status", v, 32'h20);
    irq_in[5] = 1'b1; idle(3);
    chk("R4 deassert cascade", {31'b0, cascade_irq}, 0);
    wr(A_POL, 32'h200); irq_in[9] = 1'b1; idle(3);
    rd(A_STS, v); chk("R4 active-high status", v, 32'h200);
    chk("R9 not enabled", {31'b0, cascade_irq}, 0);
    wr(A_ENA, 32'h220);
    chk("R9 enabled pending", {31'b0, cascade_irq}, 1);
    wr(A_CTRL, 0);
    chk("R9 global off", {31'b0, cascade_irq}, 0);
    wr(A_CTRL, 32'h8000_0000);
    chk("R9 global on", {31'b0, cascade_irq}, 1);
  endtask

  task automatic t_level_clear();
    logic [31:0] v;
    wr(A_CLR, 32'h200);
    rd(A_STS, v); chk("R8 level clear overridden", v, 32'h200);
    irq_in[9] = 1'b0; idle(3);
    rd(A_STS, v); chk("R8 level inactive", v, 0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    @(negedge clk); bus_addr = A_ENA; bus_we = 1'b1; bus_wdata = 32'h0_0A5A;
    @(negedge clk); chk("R11 old value on write edge", bus_rdata, 32'h220);
    bus_we = 1'b0;
    @(negedge clk); chk("R11 new value next read", bus_rdata, 32'h0_0A5A);
    bus_addr = 8'h40;
    wr(A_ENA, 32'h220);
    rd(A_ENA, v); chk("R11 restore", v, 32'h220);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(A_CTRL, 32'hC000_0000); wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_STS, v); chk("R5 start clear", v, 0);
    @(negedge clk); irq_in[9] = 1'b1;
    @(negedge clk); irq_in[9] = 1'b0;
    idle(5);
    rd(A_STS, v); chk("R5 pulse held", v, 32'h200);
    chk("R5 cascade from edge", {31'b0, cascade_irq}, 1);
    irq_in[2] = 1'b0; idle(4);
    rd(A_STS, v); chk("R5 active-low edge", v, 32'h204);
    wr(A_CLR, 0);
    rd(A_STS, v); chk("R6 zero write no effect", v, 32'h204);
    wr(A_CLR, 32'h200);
    rd(A_STS, v); chk("R6 clear one bit", v, 32'h4);
    chk("R6 cascade after clear", {31'b0, cascade_irq}, 0);
    wr(A_CLR, 32'h4); idle(2);
    rd(A_STS, v); chk("R6 stays clear while active", v, 0);
    rd(A_CLR, v); chk("R6 clear reads zero", v, 0);
    irq_in[2] = 1'b1; idle(3);
  endtask

  task automatic t_edge_wins();
    logic [31:0] v;
    @(negedge clk); irq_in[7] = 1'b0;
    @(negedge clk);
    @(negedge clk); bus_addr = A_CLR; bus_we = 1'b1; bus_wdata = 32'h80;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h40;
    rd(A_STS, v); chk("R7 edge beats clear", v, 32'h80);
    wr(A_CLR, 32'h80);
    rd(A_STS, v); chk("R7 later clear", v, 0);
    irq_in[7] = 1'b1; idle(3);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h14, v); chk("R10 read 0x14", v, 0);
    rd(8'h1C, v); chk("R10 read 0x1C", v, 0);
    rd(8'h05, v); chk("R10 read misaligned", v, 0);
    wr(8'h14, 32'hFFFF_FFFF); wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h84, 32'hFFFF_FFFF); wr(8'h90, 32'hFFFF_FFFF);
    rd(A_ENA, v);  chk("R10 enable unchanged", v, 32'h220);
    rd(A_POL, v);  chk("R10 polarity unchanged", v, 32'h200);
    rd(A_CTRL, v); chk("R10 ctrl unchanged", v, 32'hC000_0000);
    rd(A_STS, v);  chk("R10 status unchanged", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_level();
    t_level_clear();
    t_latency();
    t_edge();
    t_edge_wins();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule